// File: doc/BRIEF.md
# SPI-Mode Memory Card Command Engine

This block issues one command to a memory card running in SPI mode and collects the card's one-byte R1 status. A one-cycle start pulse hands it a 6-bit command index and a 32-bit argument. It builds a seven-byte command frame and computes the 7-bit checksum in hardware while the frame is being sent. It pushes each byte to an external bit-level SPI shifter through a byte request/acknowledge handshake. After the frame it clocks filler bytes to poll for the status byte, then classifies that byte into three flags: no card present, checksum rejected, and other error. A one-cycle `done` pulse marks the moment the status is valid.

A second start input runs the power-up wake sequence. It clocks a fixed number of all-ones bytes with the card deselected and asks the shifter for its slow rate. Chip select stays low for the whole frame and poll exchange of a command, and goes high again when that exchange ends.

Top module: `sdspi_cmd_engine`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_req`, `done`, `busy` and all three flags are 0, and `resp_r1` reads 0xFF.
- R2: A command sends seven bytes in this order: 0xFF, then 0x40 OR the 6-bit index, then the argument most significant byte first, then the trailer. `spi_cs_n` is 0 for every one of these bytes.
- R3: The trailer is {crc7, 1'b1}, where crc7 is the remainder of the five bytes from index to argument (MSB first) under polynomial x^7+x^3+1 with a zero start value. Index 0 with a zero argument gives 0x95, and index 8 with argument 0x000001AA gives 0x87.
- R4: `spi_req` stays high with `spi_tx` unchanged until `spi_ack` is seen. Each `spi_ack` pulse completes exactly one byte.
- R5: After the frame the block sends 0xFF poll bytes. The first poll byte is never taken as the status. The first later byte with bit 7 equal to 0 is taken, and no more bytes follow it.
- R6: At most POLL_LIMIT (8) poll bytes are sent. If none qualifies, the last byte read becomes `resp_r1`, and a value of 0xFF there sets `err_nocard`.
- R7: Classification of `resp_r1`: 0xFF sets only `err_nocard`. Otherwise bit 3 set sets only `err_crc`. Otherwise any set bit in positions 7..1 sets only `err_general`. A value of 0x00 or 0x01 sets no flag.
- R8: `done` is a one-cycle pulse. In that cycle `resp_r1` and the flags already hold the new result, and `spi_cs_n` is back at 1 with `spi_req` at 0.
- R9: The wake sequence sends INIT_BYTES (18) bytes of 0xFF with `spi_cs_n` = 1 and `spi_slow` = 1 on every byte. It ends with a `done` pulse and leaves `resp_r1` and the flags unchanged.
- R10: `cmd_start` and `init_start` have no effect while `busy` is 1.
- R11: If `init_start` and `cmd_start` arrive in the same idle cycle, only the wake sequence runs and the command is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | One-cycle pulse that starts a command |
| cmd_index | input | 6 | Command index, sampled with cmd_start |
| cmd_arg | input | 32 | Command argument, sampled with cmd_start |
| init_start | input | 1 | One-cycle pulse that starts the wake sequence |
| busy | output | 1 | A command or wake sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| resp_r1 | output | 8 | Last captured status byte |
| err_nocard | output | 1 | Status byte was 0xFF |
| err_crc | output | 1 | Card reported a command checksum error |
| err_general | output | 1 | Card reported any other error bit |
| spi_req | output | 1 | Byte transfer request to the shifter |
| spi_tx | output | 8 | Byte to shift out |
| spi_ack | input | 1 | One-cycle pulse: current byte finished |
| spi_rx | input | 8 | Byte shifted in, valid with spi_ack |
| spi_cs_n | output | 1 | Card chip select, active low |
| spi_slow | output | 1 | Asks the shifter for the slow wake rate |

## Verification
The two start inputs can land in the same idle cycle. The bench provokes this by raising `cmd_start` and `init_start` on the same edge. It then judges the result at the shifter port: exactly eighteen 0xFF bytes must appear with the card deselected, and no command frame may follow. A related collision is a start that arrives while a command is in flight. The bench raises both starts in the middle of a slow-acknowledged command and checks that the frame and the byte count still belong to the original command, and that nothing runs afterwards.

// File: rtl/sdspi_pkg.sv
// Package: shared state encoding and status flag bundle for the
// SPI-mode card command engine. Assumes nothing beyond IEEE 1800-2017.
package sdspi_pkg;

    // Sequencer phases of the command engine.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INIT  = 2'd1,
        ST_FRAME = 2'd2,
        ST_POLL  = 2'd3
    } sd_state_e;

    // Classified status of one R1 byte; at most one member is set.
    typedef struct packed {
        logic nocard;
        logic crc;
        logic general;
    } sd_flags_t;

    localparam logic [7:0] FILL_BYTE = 8'hFF;

endpackage

// File: rtl/sdspi_crc7.sv
// Module: sdspi_crc7
// Running 7-bit checksum (x^7 + x^3 + 1, zero seed) over command bytes.
// Each update folds one byte in MSB first through an unrolled bit-serial
// loop. Assumes clear and upd are never both high in the same cycle.
module sdspi_crc7 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       upd,
    input  logic [7:0] din,
    output logic [6:0] crc
);
    logic [6:0] crc_next;

    // Fold eight data bits into the current remainder, MSB first.
    always_comb begin
        logic [6:0] c;
        logic       fb;
        c = crc;
        for (int i = 7; i >= 0; i--) begin
            fb = c[6] ^ din[i];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        crc_next = c;
    end

    // Hold, clear or advance the remainder register.
    always_ff @(posedge clk) begin
        if (!rst_n)     crc <= '0;
        else if (clear) crc <= '0;
        else if (upd)   crc <= crc_next;
    end

    // R3
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !upd) |=> $stable(crc));

endmodule

// File: rtl/sdspi_frame_mux.sv
// Module: sdspi_frame_mux
// Selects the outgoing byte of a seven-byte command frame by position.
// Assumes position 0..6; any other position yields the filler byte.
module sdspi_frame_mux (
    input  logic [2:0]  pos,
    input  logic [5:0]  cmd_idx,
    input  logic [31:0] arg,
    input  logic [6:0]  crc,
    output logic [7:0]  frame_byte
);
    import sdspi_pkg::*;

    // Byte lane selection for the current frame position.
    always_comb begin
        case (pos)
            3'd0:    frame_byte = FILL_BYTE;
            3'd1:    frame_byte = {2'b01, cmd_idx};
            3'd2:    frame_byte = arg[31:24];
            3'd3:    frame_byte = arg[23:16];
            3'd4:    frame_byte = arg[15:8];
            3'd5:    frame_byte = arg[7:0];
            3'd6:    frame_byte = {crc, 1'b1};
            default: frame_byte = FILL_BYTE;
        endcase
    end

endmodule

// File: rtl/sdspi_r1_classify.sv
// Module: sdspi_r1_classify
// Maps one status byte to mutually exclusive flags with priority
// no-card > checksum error > other error. Purely combinational.
module sdspi_r1_classify (
    input  logic [7:0]           r1,
    output sdspi_pkg::sd_flags_t flags
);
    logic all_ones;

    // Priority decode of the status byte.
    always_comb begin
        all_ones      = (r1 == 8'hFF);
        flags.nocard  = all_ones;
        flags.crc     = !all_ones && r1[3];
        flags.general = !all_ones && !r1[3] && (|r1[7:1]);
    end

    // R7
    flag_excl_chk: assert final ($onehot0({flags.nocard, flags.crc, flags.general}));

endmodule

// File: rtl/sdspi_cmd_engine.sv
// Module: sdspi_cmd_engine (top)
// Sequences a wake run or a command frame plus status poll over a byte
// request/ack link to an external SPI shifter. Assumes the shifter
// returns one single-cycle spi_ack per requested byte and samples spi_tx
// while spi_req is high.
module sdspi_cmd_engine #(
    parameter int INIT_BYTES = 18,
    parameter int POLL_LIMIT = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_start,
    input  logic [5:0]  cmd_index,
    input  logic [31:0] cmd_arg,
    input  logic        init_start,
    output logic        busy,
    output logic        done,
    output logic [7:0]  resp_r1,
    output logic        err_nocard,
    output logic        err_crc,
    output logic        err_general,
    output logic        spi_req,
    output logic [7:0]  spi_tx,
    input  logic        spi_ack,
    input  logic [7:0]  spi_rx,
    output logic        spi_cs_n,
    output logic        spi_slow
);
    import sdspi_pkg::*;

    localparam int FRAME_BYTES = 7;
    localparam int CNT_MAX     = INIT_BYTES + POLL_LIMIT + FRAME_BYTES;
    localparam int CNT_W       = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] INIT_LAST  = CNT_W'(INIT_BYTES - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BYTES - 1);
    localparam logic [CNT_W-1:0] POLL_LAST  = CNT_W'(POLL_LIMIT - 1);
    localparam logic [CNT_W-1:0] POLL_CAP   = CNT_W'(POLL_LIMIT);

    sd_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [5:0]       idx_q;
    logic [31:0]      arg_q;
    logic [6:0]       crc_val;
    logic [7:0]       frame_byte;
    logic             crc_clear;
    logic             crc_upd;
    logic             take_resp;
    sd_flags_t        rx_flags;
    sd_flags_t        flags_q;

    // Checksum accumulator over frame bytes 1..5.
    sdspi_crc7 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (crc_clear),
        .upd   (crc_upd),
        .din   (frame_byte),
        .crc   (crc_val)
    );

    // Frame byte selection by position.
    sdspi_frame_mux u_mux (
        .pos        (cnt[2:0]),
        .cmd_idx    (idx_q),
        .arg        (arg_q),
        .crc        (crc_val),
        .frame_byte (frame_byte)
    );

    // Status classification of the incoming byte.
    sdspi_r1_classify u_cls (
        .r1    (spi_rx),
        .flags (rx_flags)
    );

    // Checksum control: clear on command accept, fold bytes 1..5 on ack.
    always_comb begin
        crc_clear = (state == ST_IDLE) && cmd_start && !init_start;
        crc_upd   = (state == ST_FRAME) && spi_ack &&
                    (cnt >= CNT_W'(1)) && (cnt <= CNT_W'(5));
    end

    // Poll acceptance: never the first poll byte, else first with bit7 clear, or the last.
    always_comb begin
        take_resp = ((cnt != '0) && !spi_rx[7]) || (cnt == POLL_LAST);
    end

    // Link-side outputs derived from the current phase.
    always_comb begin
        busy     = (state != ST_IDLE);
        spi_req  = (state != ST_IDLE);
        spi_cs_n = !((state == ST_FRAME) || (state == ST_POLL));
        spi_slow = (state == ST_INIT);
        spi_tx   = (state == ST_FRAME) ? frame_byte : FILL_BYTE;
    end

    // Main sequencer: phase, byte counter, latched command and result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            idx_q   <= '0;
            arg_q   <= '0;
            done    <= 1'b0;
            resp_r1 <= FILL_BYTE;
            flags_q <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (init_start) begin
                        state <= ST_INIT;
                        cnt   <= '0;
                    end else if (cmd_start) begin
                        state <= ST_FRAME;
                        cnt   <= '0;
                        idx_q <= cmd_index;
                        arg_q <= cmd_arg;
                    end
                end
                ST_INIT: begin
                    if (spi_ack) begin
                        if (cnt == INIT_LAST) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_FRAME: begin
                    if (spi_ack) begin
                        if (cnt == FRAME_LAST) begin
                            state <= ST_POLL;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_POLL: begin
                    if (spi_ack) begin
                        if (take_resp) begin
                            state   <= ST_IDLE;
                            done    <= 1'b1;
                            resp_r1 <= spi_rx;
                            flags_q <= rx_flags;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign err_nocard  = flags_q.nocard;
    assign err_crc     = flags_q.crc;
    assign err_general = flags_q.general;

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (spi_cs_n && !spi_req));

    // R5
    first_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POLL && cnt == '0 && spi_ack) |=> !done);

    // R6
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POLL) |-> (cnt < POLL_CAP));

    // R6
    nocard_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_nocard |-> (resp_r1 == 8'hFF));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_start) |=> ($stable(idx_q) && $stable(arg_q)));

endmodule

// File: tb/sdspi_cmd_engine_bench.sv
// Directed bench with a card model behind a byte-level shifter model.
module sdspi_cmd_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic        init_start = 1'b0;
    logic        busy, done, err_nocard, err_crc, err_general;
    logic [7:0]  resp_r1;
    logic        spi_req, spi_cs_n, spi_slow;
    logic [7:0]  spi_tx;
    logic        spi_ack = 1'b0;
    logic [7:0]  spi_rx = 8'hFF;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    sdspi_cmd_engine u_sdspi_cmd_engine (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_index(cmd_index),
        .cmd_arg(cmd_arg), .init_start(init_start), .busy(busy), .done(done),
        .resp_r1(resp_r1), .err_nocard(err_nocard), .err_crc(err_crc),
        .err_general(err_general), .spi_req(spi_req), .spi_tx(spi_tx),
        .spi_ack(spi_ack), .spi_rx(spi_rx), .spi_cs_n(spi_cs_n), .spi_slow(spi_slow)
    );

    // ---------------- shifter + card model ----------------
    int         lat = 0;
    int         filler = 1;
    logic [7:0] first_byte = 8'hFF;
    logic [7:0] r1_val = 8'h01;
    int         lat_cnt = 0;
    int         sel_cnt = 0;
    int         acks_total = 0;
    int         stab_err = 0;
    logic [7:0] snap = 8'h00;
    logic [7:0] tx_log [0:1023];
    logic       cs_log [0:1023];
    logic       slow_log [0:1023];

    function automatic logic [7:0] card_byte(input int k);
        if (k == 0)      return first_byte;
        if (k < filler)  return 8'hFF;
        return r1_val;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            spi_ack <= 1'b0;
            lat_cnt <= 0;
            sel_cnt <= 0;
        end else if (spi_ack) begin
            spi_ack <= 1'b0;
            if (spi_cs_n) sel_cnt <= 0;
        end else if (spi_req) begin
            if (lat_cnt == 0) snap <= spi_tx;
            else if (spi_tx != snap) stab_err <= stab_err + 1;
            if (lat_cnt >= lat) begin
                spi_ack <= 1'b1;
                lat_cnt <= 0;
                if (acks_total < 1024) begin
                    tx_log[acks_total]   <= spi_tx;
                    cs_log[acks_total]   <= spi_cs_n;
                    slow_log[acks_total] <= spi_slow;
                end
                acks_total <= acks_total + 1;
                if (spi_cs_n || sel_cnt < 7) spi_rx <= 8'hFF;
                else spi_rx <= card_byte(sel_cnt - 7);
                if (spi_cs_n) sel_cnt <= 0;
                else sel_cnt <= sel_cnt + 1;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end else if (spi_cs_n) begin
            sel_cnt <= 0;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc7(input logic [39:0] msg);
        logic [46:0] work;
        work = {msg, 7'b0};
        for (int i = 46; i >= 7; i--)
            if (work[i]) work[i -: 8] = work[i -: 8] ^ 8'b1000_1001;
        return work[6:0];
    endfunction

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(req, "done seen", {31'b0, done}, 32'd1);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1", "cs_n", {31'b0, spi_cs_n}, 32'd1);
        chk("R1", "req", {31'b0, spi_req}, 32'd0);
        chk("R1", "done", {31'b0, done}, 32'd0);
        chk("R1", "busy", {31'b0, busy}, 32'd0);
        chk("R1", "r1", {24'b0, resp_r1}, 32'hFF);
        chk("R1", "flags", {29'b0, err_nocard, err_crc, err_general}, 32'd0);
    endtask

    task automatic t_cmd(input logic [5:0] idx, input logic [31:0] arg,
                         input int fl, input logic [7:0] first, input logic [7:0] r1v,
                         input int latency, input int exp_polls,
                         input logic [7:0] exp_r1, input logic [2:0] exp_flags);
        int base;
        logic [7:0] cmdb;
        cmdb = {2'b01, idx};
        filler = fl; first_byte = first; r1_val = r1v; lat = latency;
        base = acks_total;
        @(negedge clk);
        cmd_index = idx; cmd_arg = arg; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        wait_done("R8");
        chk("R8", "cs_n at done", {31'b0, spi_cs_n}, 32'd1);
        chk("R6", "byte count", acks_total - base, 7 + exp_polls);
        chk("R2", "byte0", {24'b0, tx_log[base]}, 32'hFF);
        chk("R2", "cmd byte", {24'b0, tx_log[base+1]}, {24'b0, cmdb});
        chk("R2", "arg bytes", {tx_log[base+2], tx_log[base+3], tx_log[base+4], tx_log[base+5]}, arg);
        chk("R3", "trailer", {24'b0, tx_log[base+6]}, {24'b0, ref_crc7({cmdb, arg}), 1'b1});
        for (int i = 0; i < 7 + exp_polls; i++)
            chk("R2", "cs low", {31'b0, cs_log[base+i]}, 32'd0);
        for (int i = 7; i < 7 + exp_polls; i++)
            chk("R5", "poll fill", {24'b0, tx_log[base+i]}, 32'hFF);
        chk("R7", "r1", {24'b0, resp_r1}, {24'b0, exp_r1});
        chk("R7", "flags", {29'b0, err_nocard, err_crc, err_general}, {29'b0, exp_flags});
        @(negedge clk);
        chk("R8", "done width", {31'b0, done}, 32'd0);
    endtask

    task automatic t_init(input logic both);
        int base;
        logic [7:0] r1_before;
        logic [2:0] fl_before;
        r1_before = resp_r1;
        fl_before = {err_nocard, err_crc, err_general};
        lat = 1;
        base = acks_total;
        @(negedge clk);
        init_start = 1'b1;
        if (both) begin cmd_start = 1'b1; cmd_index = 6'd17; end
        @(negedge clk);
        init_start = 1'b0; cmd_start = 1'b0;
        wait_done("R9");
        chk("R9", "init bytes", acks_total - base, 32'd18);
        for (int i = 0; i < 18; i++) begin
            chk("R9", "init tx", {24'b0, tx_log[base+i]}, 32'hFF);
            chk("R9", "init cs_n", {31'b0, cs_log[base+i]}, 32'd1);
            chk("R9", "init slow", {31'b0, slow_log[base+i]}, 32'd1);
        end
        chk("R9", "r1 kept", {24'b0, resp_r1}, {24'b0, r1_before});
        chk("R9", "flags kept", {29'b0, err_nocard, err_crc, err_general}, {29'b0, fl_before});
        repeat (40) @(negedge clk);
        if (both) chk("R11", "no command after", acks_total - base, 32'd18);
        else      chk("R9", "idle after", {31'b0, busy}, 32'd0);
    endtask

    task automatic t_busy();
        int base;
        filler = 3; first_byte = 8'hFF; r1_val = 8'h00; lat = 4;
        base = acks_total;
        @(negedge clk);
        cmd_index = 6'd24; cmd_arg = 32'hCAFE_0001; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        repeat (6) @(negedge clk);
        cmd_index = 6'd55; cmd_arg = 32'h0; cmd_start = 1'b1; init_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0; init_start = 1'b0;
        wait_done("R10");
        chk("R10", "cmd byte kept", {24'b0, tx_log[base+1]}, 32'h58);
        chk("R10", "arg kept", {tx_log[base+2], tx_log[base+3], tx_log[base+4], tx_log[base+5]}, 32'hCAFE_0001);
        chk("R10", "byte count", acks_total - base, 32'd11);
        repeat (40) @(negedge clk);
        chk("R10", "nothing after", acks_total - base, 32'd11);
        chk("R10", "idle", {31'b0, busy}, 32'd0);
        chk("R4", "tx stable under req", stab_err, 32'd0);
    endtask

    // ---------------- main ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init(1'b0);
        // CMD0: fixed trailer 0x95, R1 idle
        t_cmd(6'd0, 32'h0, 1, 8'hFF, 8'h01, 0, 2, 8'h01, 3'b000);
        chk("R3", "cmd0 trailer 0x95", {24'b0, tx_log[acks_total-9+6]}, 32'h95);
        // CMD8: fixed trailer 0x87
        t_cmd(6'd8, 32'h0000_01AA, 2, 8'hFF, 8'h01, 3, 3, 8'h01, 3'b000);
        chk("R3", "cmd8 trailer 0x87", {24'b0, tx_log[acks_total-10+6]}, 32'h87);
        // first poll byte valid-looking but ignored
        t_cmd(6'd17, 32'h1234_5678, 0, 8'h00, 8'h04, 0, 2, 8'h04, 3'b001);
        // accepted on the very last poll byte
        t_cmd(6'd63, 32'hFFFF_FFFF, 7, 8'hFF, 8'h00, 2, 8, 8'h00, 3'b000);
        // no card: all 0xFF
        t_cmd(6'd9, 32'h8000_0000, 8, 8'hFF, 8'h00, 0, 8, 8'hFF, 3'b100);
        // checksum error with another bit set: crc only
        t_cmd(6'd13, 32'h0000_0000, 1, 8'hFF, 8'h0D, 0, 2, 8'h0D, 3'b010);
        // bit7 never clears: last byte 0x80 gives general error
        t_cmd(6'd2, 32'hA5A5_5A5A, 1, 8'hFF, 8'h80, 1, 8, 8'h80, 3'b001);
        // status retained across a wake run
        t_init(1'b0);
        t_busy();
        t_init(1'b1);
        chk("R4", "tx stable under req", stab_err, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule